// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical reference, a segment number plus an offset into that segment, into a physical address. A small table holds one base address, one length and one valid flag per segment. A configuration port loads the table entries. The translation port takes a segment number and an offset. One cycle later it returns either the physical address, which is the base plus the offset, or an illegal-reference trap with a cause code.

Software loads the table for the running program, then issues references. A reference traps when it names an entry that is not valid, when its offset reaches or passes the segment's length, or when the base plus the offset does not fit in the address width. Two entries may be given the same base. Both segments then resolve to the same physical locations, which lets a segment be shared.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid, and all response outputs (`rspValid`, `rspAddr`, `rspTrap`, `rspCause`) are 0. A reference made right after reset traps with cause 1.
- R2: A response appears exactly one clock after a cycle with `reqValid` high, and `rspValid` is high in that cycle.
- R3: For a valid entry with offset below its length and no carry, `rspAddr` equals the base plus the offset, `rspTrap` is 0 and `rspCause` is 0. For example, base 219 and offset 430 give 649.
- R4: An offset greater than or equal to the entry's length traps with cause 2. Offset length-1 is still legal, and a length of 0 always traps.
- R5: A reference to an invalid entry traps with cause 1. This cause takes priority over the length and carry checks.
- R6: If the base plus the offset carries out of the 16-bit address width, the reference traps with cause 3. A sum of exactly 0xFFFF is legal.
- R7: Whenever `rspTrap` is 1, `rspAddr` is 0 and `rspCause` is nonzero. Whenever `rspTrap` is 0, `rspCause` is 0.
- R8: A configuration write and a translation of the same segment in the same cycle use the old entry. The written entry applies from the next cycle on.
- R9: Two entries written with the same base translate the same offset to the same physical address.
- R10: In a response cycle that follows a cycle without a request, `rspValid`, `rspAddr`, `rspTrap` and `rspCause` are all 0.
- R11: A configuration write with `cfgValid` low makes that entry invalid, so later references to it trap with cause 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Table write strobe |
| cfgSeg | input | 3 | Entry to write |
| cfgBase | input | 16 | Base address to store |
| cfgLen | input | 16 | Segment length to store |
| cfgValid | input | 1 | Valid flag to store |
| reqValid | input | 1 | Translation request strobe |
| reqSeg | input | 3 | Segment number of the reference |
| reqOff | input | 16 | Offset within the segment |
| rspValid | output | 1 | Response present (one cycle after the request) |
| rspAddr | output | 16 | Physical address, 0 on a trap |
| rspTrap | output | 1 | Illegal-reference trap |
| rspCause | output | 2 | 0 none, 1 invalid entry, 2 length, 3 carry |

## Verification
The translator is driven with the worked reference set (legal references to segments 0, 1 and 3, length violations on segments 2 and 4). This set separates the add path from the compare path. Directed boundary references follow: offsets of length-1 and of length, a zero-length entry, and sums of 0xFFFF and 0x10000. These cases catch off-by-one comparisons and a dropped carry. Further directed cases cover a write colliding with a read of the same entry, an invalidating write, and two entries sharing a base, which tell old-entry reads apart from new-entry reads. A long stretch of random writes, references and idle cycles, checked against a behavioural model, then exercises the cause priority.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_INVALID = 2'd1,
    CAUSE_LIMIT   = 2'd2,
    CAUSE_CARRY   = 2'd3
  } trap_cause_e;

  typedef struct packed {
    logic tableWr;
    logic rspLoad;
    logic rspIdle;
  } xlate_strobe_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfgWe,
  input  logic          reqValid,
  output xlate_strobe_t strobe,
  output logic          rspValid
);

  always_comb begin
    strobe.tableWr = cfgWe;
    strobe.rspLoad = reqValid;
    strobe.rspIdle = !reqValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rspValid <= 1'b0;
    else        rspValid <= reqValid;
  end

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int ADDR_W  = 16,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xlate_strobe_t     strobe,
  input  logic [SEG_W-1:0]  cfgSeg,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLen,
  input  logic              cfgValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqOff,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspTrap,
  output logic [1:0]        rspCause
);

  logic [ADDR_W-1:0] baseMem [NUM_SEG];
  logic [ADDR_W-1:0] lenMem  [NUM_SEG];
  logic [NUM_SEG-1:0] validMem;

  // Table storage: one write port, reads see the pre-edge contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validMem <= '0;
      for (int i = 0; i < NUM_SEG; i++) begin
        baseMem[i] <= '0;
        lenMem[i]  <= '0;
      end
    end else if (strobe.tableWr && (int'(cfgSeg) < NUM_SEG)) begin
      validMem[cfgSeg] <= cfgValid;
      baseMem[cfgSeg]  <= cfgBase;
      lenMem[cfgSeg]   <= cfgLen;
    end
  end

  // Lookup
  logic              inRange;
  logic              selValid;
  logic [ADDR_W-1:0] selBase;
  logic [ADDR_W-1:0] selLen;
  logic [ADDR_W:0]   sum;
  trap_cause_e       cause;

  always_comb begin
    inRange  = int'(reqSeg) < NUM_SEG;
    selValid = inRange ? validMem[reqSeg] : 1'b0;
    selBase  = inRange ? baseMem[reqSeg] : '0;
    selLen   = inRange ? lenMem[reqSeg] : '0;
    sum      = {1'b0, selBase} + {1'b0, reqOff};
    if (!selValid)            cause = CAUSE_INVALID;
    else if (reqOff >= selLen) cause = CAUSE_LIMIT;
    else if (sum[ADDR_W])     cause = CAUSE_CARRY;
    else                      cause = CAUSE_NONE;
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspAddr  <= '0;
      rspTrap  <= 1'b0;
      rspCause <= 2'd0;
    end else if (strobe.rspLoad) begin
      rspCause <= cause;
      rspTrap  <= (cause != CAUSE_NONE);
      rspAddr  <= (cause == CAUSE_NONE) ? sum[ADDR_W-1:0] : '0;
    end else if (strobe.rspIdle) begin
      rspAddr  <= '0;
      rspTrap  <= 1'b0;
      rspCause <= 2'd0;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int ADDR_W  = 16,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [SEG_W-1:0]  cfgSeg,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLen,
  input  logic              cfgValid,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqOff,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspTrap,
  output logic [1:0]        rspCause
);

  xlate_strobe_t strobe;

  seg_xlate_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWe    (cfgWe),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  seg_xlate_dp #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .cfgSeg   (cfgSeg),
    .cfgBase  (cfgBase),
    .cfgLen   (cfgLen),
    .cfgValid (cfgValid),
    .reqSeg   (reqSeg),
    .reqOff   (reqOff),
    .rspAddr  (rspAddr),
    .rspTrap  (rspTrap),
    .rspCause (rspCause)
  );

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check #(
  parameter int NUM_SEG = 8,
  parameter int ADDR_W  = 16,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgWe,
  input logic [SEG_W-1:0]  cfgSeg,
  input logic              cfgValid,
  input logic              reqValid,
  input logic [SEG_W-1:0]  reqSeg,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              rspTrap,
  input logic [1:0]        rspCause
);

  // Valid flags rebuilt from the configuration port alone.
  logic [NUM_SEG-1:0] shadowValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadowValid <= '0;
    else if (cfgWe && (int'(cfgSeg) < NUM_SEG)) shadowValid[cfgSeg] <= cfgValid;
  end

  logic reqInvalid;
  assign reqInvalid = (int'(reqSeg) >= NUM_SEG) || !shadowValid[reqSeg];

  p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!rspValid && !rspTrap && rspAddr == '0 && rspCause == 2'd0));

  p_trap_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rspTrap |-> (rspAddr == '0 && rspCause != 2'd0));

  p_cause_needs_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rspTrap |-> (rspCause == 2'd0));

  p_invalid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqInvalid) |=> (rspTrap && rspCause == 2'd1));

endmodule

bind seg_xlate seg_xlate_check #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfgWe    (cfgWe),
  .cfgSeg   (cfgSeg),
  .cfgValid (cfgValid),
  .reqValid (reqValid),
  .reqSeg   (reqSeg),
  .rspValid (rspValid),
  .rspAddr  (rspAddr),
  .rspTrap  (rspTrap),
  .rspCause (rspCause)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSeg = '0;
  logic [15:0] cfgBase = '0;
  logic [15:0] cfgLen = '0;
  logic        cfgValid = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqSeg = '0;
  logic [15:0] reqOff = '0;
  logic        rspValid;
  logic [15:0] rspAddr;
  logic        rspTrap;
  logic [1:0]  rspCause;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfgWe(cfgWe), .cfgSeg(cfgSeg), .cfgBase(cfgBase), .cfgLen(cfgLen), .cfgValid(cfgValid),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqOff(reqOff),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspTrap(rspTrap), .rspCause(rspCause)
  );

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  // Behavioural model of the table
  int mBase [8];
  int mLen  [8];
  bit mValid[8];

  task automatic compare(input string tag, input bit eV, input int eA, input bit eT, input int eC);
    checkCount++;
    if (rspValid !== eV || int'(rspAddr) != eA || rspTrap !== eT || int'(rspCause) != eC) begin
      failCount++;
      $display("FAIL %s: got valid=%0d addr=%0d trap=%0d cause=%0d, expected valid=%0d addr=%0d trap=%0d cause=%0d",
               tag, rspValid, rspAddr, rspTrap, rspCause, eV, eA, eT, eC);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check the response next falling edge.
  task automatic cycle(input bit we, input int wSeg, input int wBase, input int wLen, input bit wVld,
                       input bit rv, input int rSeg, input int rOff, input string tagIn);
    bit eV; int eA; bit eT; int eC; string tag;
    cfgWe = we; cfgSeg = 3'(wSeg); cfgBase = 16'(wBase); cfgLen = 16'(wLen); cfgValid = wVld;
    reqValid = rv; reqSeg = 3'(rSeg); reqOff = 16'(rOff);
    eV = rv; eA = 0; eT = 0; eC = 0;
    if (rv) begin
      if (!mValid[rSeg])                  eC = 1;
      else if (rOff >= mLen[rSeg])        eC = 2;
      else if (mBase[rSeg] + rOff > 65535) eC = 3;
      else                                eA = mBase[rSeg] + rOff;
      eT = (eC != 0);
    end
    if (tagIn != "") tag = tagIn;
    else if (!rv)    tag = "R10";
    else if (eC == 1) tag = "R5";
    else if (eC == 2) tag = "R4";
    else if (eC == 3) tag = "R6";
    else             tag = "R3";
    if (we) begin
      mBase[wSeg] = wBase; mLen[wSeg] = wLen; mValid[wSeg] = wVld;
    end
    @(negedge clk);
    compare(tag, eV, eA, eT, eC);
  endtask

  task automatic wr(input int s, input int b, input int l);
    cycle(1, s, b, l, 1, 0, 0, 0, "R10");
  endtask

  task automatic rd(input int s, input int o, input string tag);
    cycle(0, 0, 0, 0, 0, 1, s, o, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mBase[i] = 0; mLen[i] = 0; mValid[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R1", 0, 0, 0, 0);           // outputs held at zero in reset
    rst_n = 1'b1;
    cycle(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    rd(0, 0, "R1");                       // table empty after reset
    rd(7, 5, "R1");

    wr(0, 219, 600); wr(1, 2300, 14); wr(2, 90, 100); wr(3, 1327, 580); wr(4, 1952, 96);
    rd(0, 430, "R3");                     // 649
    rd(1, 10, "R3");                      // 2310
    rd(2, 500, "R4");                     // trap
    rd(3, 400, "R2");                     // back-to-back responses, 1727
    rd(4, 112, "R7");                     // trap, address forced to 0
    cycle(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    rd(2, 99, "R4");                      // length-1 legal
    rd(2, 100, "R4");                     // length traps
    wr(7, 500, 0);
    rd(7, 0, "R4");                       // zero length
    rd(5, 3, "R5");                       // never written
    wr(6, 16'hFFF0, 16'hFFFF);
    rd(6, 16'h000F, "R6");                // 0xFFFF legal
    rd(6, 16'h0010, "R6");                // carry
    wr(5, 219, 600);
    rd(5, 430, "R9");                     // shares base of segment 0
    rd(0, 430, "R9");
    cycle(1, 1, 5000, 40, 1, 1, 1, 10, "R8"); // old entry: 2310
    rd(1, 10, "R8");                      // new entry: 5010
    cycle(1, 3, 1327, 580, 0, 0, 0, 0, "R11");
    rd(3, 400, "R11");
    cycle(1, 2, 0, 0, 0, 1, 2, 50, "R8");   // old entry still valid: 140
    rd(2, 50, "R11");

    for (int n = 0; n < 400; n++) begin
      bit we; bit rv;
      we = ($urandom % 4) == 0;
      rv = ($urandom % 5) != 0;
      cycle(we, int'($urandom % 8), int'($urandom % 65536), int'($urandom % 4096), ($urandom % 6) != 0,
            rv, int'($urandom % 8), int'(($urandom % 2) ? $urandom % 4096 : $urandom % 65536), "");
    end

    cycle(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule